// File: doc/BRIEF.md
# Self-Clocked Serial Result Sequencer

This block is the device end of a three-wire serial read port on a converter that makes its own serial clock. When a conversion completes, the converter signals it with a one-cycle strobe and a signed result. The block stores the result as a 32-bit word in a static shift register. If chip select is high it sleeps and keeps the word. Once chip select falls and stays low through a short test interval, the block sends the word MSB first. The first bit shown is a ready flag.

Two clock modes exist. In internal mode the block drives the serial clock itself, deriving it from the oscillator clock. The clock idles high, and each low or high phase lasts a set number of oscillator cycles. In external mode the block drives no clock. It follows the falling and rising edges of the pin level that it samples. The mode is chosen each time chip select falls, from the level seen on the clock pin at that moment.

A frame ends after the 32nd rising clock edge, or earlier if chip select goes high. Either way the block starts a new conversion at once. The conversion is signalled by a one-cycle start pulse to the analog side.

Top module: `serial_result_seq`

## Requirements
- R1: An internal-mode frame drives the clock output enable for exactly 64 x HALF_CYC oscillator cycles. It starts with a low phase and alternates phases of HALF_CYC cycles each, which gives exactly 32 rising edges.
- R2: The word goes out MSB first. Bit 31 is the ready flag (0 = result valid), bit 30 is 0, bit 29 is the sign, and bits 28..0 are the result. Data changes only while the clock is low, so every bit is stable across its rising edge.
- R3: In the cycle after the phase that follows the 32nd rising edge, the clock output enable is off, the clock output reads high, and the data line is 1 while chip select stays low. A one-cycle start pulse is issued in that same cycle.
- R4: If chip select goes high during a frame, the clock drive is released in the next cycle at whatever level it had. A start pulse is issued in that cycle and the data enable goes off. The bits already sent are the leading bits of the word.
- R5: A done strobe while chip select is high places the block in sleep, where it keeps the word. Done strobes that arrive while a word is held or being sent are ignored.
- R6: The data output enable is the inverse of chip select. While a conversion runs with chip select low, the data line is 1.
- R7: At each chip-select falling edge the mode flag is loaded: 1 (external) if the clock pin is low, 0 (internal) if it is high. It changes at no other time.
- R8: Chip select must stay low for TEST_CYC cycles before a frame starts. If it rises earlier, the block goes back to sleep, gives no clock and no start pulse, and keeps the word.
- R9: In external mode the clock output enable stays off. Each falling pin edge after the first rising one moves to the next bit, and the 32nd rising pin edge ends the frame with a start pulse.
- R10: If chip select rises in the very cycle that ends a frame, exactly one start pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_pin_i | input | 1 | Sampled level of the serial clock pin |
| conv_done_i | input | 1 | One-cycle strobe marking the end of a conversion |
| conv_word_i | input | RES_W+1 | Sign (MSB) and result bits of the finished conversion |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Serial data output enable |
| sck_o | output | 1 | Generated serial clock level |
| sck_oe_o | output | 1 | Serial clock drive enable |
| ext_mode_o | output | 1 | 1 when external clock mode is selected |
| conv_start_o | output | 1 | One-cycle pulse that starts a new conversion |

## Verification
The natural end of a frame and an abort by chip select can occur in the same oscillator cycle. That happens when chip select rises during the last cycle of the high phase after the 32nd rising edge. The bench causes this by counting rising edges and raising chip select HALF_CYC-1 cycles after the 32nd one. It expects exactly one start pulse and a released clock. Random aborts at every edge position also make the clock-pin level after an abort feed into the next mode choice. That choice is judged from the mode flag.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_CONV    = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_TEST    = 3'd2,
    ST_OUT_INT = 3'd3,
    ST_OUT_EXT = 3'd4
  } srs_state_e;

  function automatic logic is_output(input srs_state_e st);
    return (st == ST_OUT_INT) || (st == ST_OUT_EXT);
  endfunction

endpackage

// File: rtl/srs_mode_sel.sv
module srs_mode_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_pin_i,
  output logic cs_fall_o,
  output logic ext_mode_o
);

  logic cs_q;
  logic ext_q;

  assign cs_fall_o = cs_q && !cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      ext_q <= 1'b0;
    end else begin
      cs_q <= cs_ni;
      if (cs_fall_o) ext_q <= !sck_pin_i;
    end
  end

  assign ext_mode_o = ext_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall_o |=> $stable(ext_mode_o)); // R7

endmodule

// File: rtl/srs_sck_gen.sv
module srs_sck_gen #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic high_end_o
);

  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             tick;

  assign tick = run_i && (cnt_q == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      lvl_q <= !lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // idles high: the line is only pulled low while a frame runs
  assign sck_o      = run_i ? lvl_q : 1'b1;
  assign rise_o     = tick && !lvl_q;
  assign high_end_o = tick && lvl_q;

endmodule

// File: rtl/srs_shreg.sv
module srs_shreg #(
  parameter int unsigned RES_W = 29
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [RES_W:0] word_i,
  input  logic           shift_i,
  output logic           msb_o
);

  localparam int unsigned WORD_W = RES_W + 3;

  // ready flag (0), zero dummy, then sign and result
  function automatic logic [WORD_W-1:0] pack_word(input logic [RES_W:0] w);
    return {1'b0, 1'b0, w};
  endfunction

  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= pack_word(word_i);
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b1};
  end

  assign msb_o = sr_q[WORD_W-1];

  AST_NO_LOAD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i)); // R5

endmodule

// File: rtl/serial_result_seq.sv
module serial_result_seq
  import srs_pkg::*;
#(
  parameter int unsigned RES_W    = 29,
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned TEST_CYC = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           sck_pin_i,
  input  logic           conv_done_i,
  input  logic [RES_W:0] conv_word_i,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic           sck_o,
  output logic           sck_oe_o,
  output logic           ext_mode_o,
  output logic           conv_start_o
);

  localparam int unsigned WORD_W = RES_W + 3;
  localparam int unsigned EDGE_W = $clog2(WORD_W + 1);
  localparam int unsigned TEST_W = (TEST_CYC > 1) ? $clog2(TEST_CYC) : 1;

  srs_state_e        state_q, state_d;
  logic [EDGE_W-1:0] edge_q;
  logic [TEST_W-1:0] test_q;
  logic              pin_q;
  logic              start_q;

  // named internal events
  logic int_run, int_rise, int_high_end;
  logic ext_rise, ext_fall;
  logic cs_fall, shift_ev, load_ev;
  logic frame_done, abort_ev, msb;

  srs_mode_sel u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_pin_i  (sck_pin_i),
    .cs_fall_o  (cs_fall),
    .ext_mode_o (ext_mode_o)
  );

  assign int_run = (state_q == ST_OUT_INT);

  srs_sck_gen #(.HALF_CYC(HALF_CYC)) u_sck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (int_run),
    .sck_o      (sck_o),
    .rise_o     (int_rise),
    .high_end_o (int_high_end)
  );

  assign ext_rise = (state_q == ST_OUT_EXT) && !pin_q && sck_pin_i;
  assign ext_fall = (state_q == ST_OUT_EXT) && pin_q && !sck_pin_i;

  assign frame_done = (int_high_end && (edge_q == EDGE_W'(WORD_W))) ||
                      (ext_rise && (edge_q == EDGE_W'(WORD_W - 1)));
  assign abort_ev   = is_output(state_q) && cs_ni;
  assign load_ev    = (state_q == ST_CONV) && conv_done_i;
  assign shift_ev   = !cs_ni &&
                      ((int_high_end && (edge_q != EDGE_W'(WORD_W))) ||
                       (ext_fall && (edge_q != '0)));

  srs_shreg #(.RES_W(RES_W)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_ev),
    .word_i  (conv_word_i),
    .shift_i (shift_ev),
    .msb_o   (msb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CONV:  if (load_ev) state_d = ST_SLEEP;
      ST_SLEEP: if (!cs_ni) state_d = ST_TEST;
      ST_TEST: begin
        if (cs_ni)                              state_d = ST_SLEEP;
        else if (test_q == TEST_W'(TEST_CYC-1)) state_d = ext_mode_o ? ST_OUT_EXT : ST_OUT_INT;
      end
      ST_OUT_INT, ST_OUT_EXT: if (abort_ev || frame_done) state_d = ST_CONV;
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CONV;
      edge_q  <= '0;
      test_q  <= '0;
      pin_q   <= 1'b1;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pin_q   <= sck_pin_i;
      start_q <= (state_q != ST_CONV) && (state_d == ST_CONV);
      test_q  <= (state_q == ST_TEST) ? test_q + 1'b1 : '0;
      if (!is_output(state_q))       edge_q <= '0;
      else if (int_rise || ext_rise) edge_q <= edge_q + 1'b1;
    end
  end

  assign conv_start_o = start_q;
  assign sck_oe_o     = int_run;
  assign sdo_oe_o     = !cs_ni;
  assign sdo_o        = ((state_q == ST_TEST) || is_output(state_q)) ? msb : 1'b1;

  AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q <= EDGE_W'(WORD_W)); // R1
  AST_SDO_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_o && sck_o && $past(sck_oe_o && sck_o)) |-> $stable(sdo_o)); // R2
  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !cs_ni) |=> (conv_start_o && sdo_o && !sck_oe_o)); // R3
  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_o && cs_ni) |=> (!sck_oe_o && conv_start_o)); // R4
  AST_TEST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_TEST) && cs_ni) |=> (state_q == ST_SLEEP)); // R8
  AST_SINGLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R10
  AST_MODE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (ext_mode_o == !$past(sck_pin_i))); // R7

endmodule

// File: tb/tb_serial_result_seq.sv
module tb_serial_result_seq;

  localparam int RES_W  = 29;
  localparam int HALF   = 4;
  localparam int TESTC  = 8;
  localparam int WORD_W = RES_W + 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, conv_done;
  logic [RES_W:0] conv_word;
  logic sdo, sdo_oe, sck, sck_oe, ext_mode, conv_start;

  // clock pin: driven by the block, by an outside driver, or held by the line
  logic ext_en = 1'b0, ext_val = 1'b1, keep_q = 1'b1;
  wire  pin = sck_oe ? sck : (ext_en ? ext_val : keep_q);
  always @(posedge clk) keep_q <= pin;

  serial_result_seq #(.RES_W(RES_W), .HALF_CYC(HALF), .TEST_CYC(TESTC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_pin_i(pin),
    .conv_done_i(conv_done), .conv_word_i(conv_word),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sck_o(sck), .sck_oe_o(sck_oe),
    .ext_mode_o(ext_mode), .conv_start_o(conv_start));

  int n_chk = 0, n_bad = 0;
  int starts = 0, oe_total = 0;
  always @(negedge clk) begin
    if (conv_start) starts++;
    if (sck_oe) oe_total++;
  end

  function automatic logic [WORD_W-1:0] exp_word(input logic [RES_W:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    r[RES_W:0] = w;            // sign and result; top two bits stay 0
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic give_result(input logic [RES_W:0] w);
    @(negedge clk); conv_done = 1'b1; conv_word = w;
    @(negedge clk); conv_done = 1'b0;
  endtask

  // internal-mode read; abort_after = 0 runs the whole frame
  task automatic read_int(input int abort_after, input int dly, output logic [31:0] got,
                          output int rises, output int oe_cyc, output logic lvl);
    logic prev;
    bit seen;
    int guard;
    @(negedge clk); cs_n = 1'b0;
    prev = sck; got = '0; rises = 0; oe_cyc = 0; seen = 0; guard = 0; lvl = 1'b1;
    while (guard < 3000) begin
      @(negedge clk); guard++;
      if (sck_oe) begin seen = 1; oe_cyc++; end
      if (sck_oe && sck && !prev) begin got = {got[30:0], sdo}; rises++; end
      prev = sck_oe ? sck : 1'b1;
      if (abort_after != 0 && rises == abort_after) begin
        repeat (dly) begin @(negedge clk); if (sck_oe) oe_cyc++; end
        lvl = sck; cs_n = 1'b1;
        break;
      end
      if (seen && !sck_oe) break;
    end
  endtask

  task automatic read_ext(input logic [RES_W:0] w);
    logic [31:0] got;
    int s0, o0;
    s0 = starts; o0 = oe_total;
    @(negedge clk); ext_en = 1'b1; ext_val = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (TESTC + 4) @(negedge clk);
    check(ext_mode == 1'b1, "R7 ext select", {31'd0, ext_mode}, 32'd1);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      got = {got[30:0], sdo};
      ext_val = 1'b1; repeat (3) @(negedge clk);
      if (i < 31) begin ext_val = 1'b0; repeat (3) @(negedge clk); end
    end
    check(got == exp_word(w), "R9 ext word", got, exp_word(w));
    check(starts == s0 + 1, "R9 ext end start", starts, s0 + 1);
    check(oe_total == o0, "R9 no clock drive", oe_total, o0);
    check(sdo == 1'b1, "R6 sdo during conversion", {31'd0, sdo}, 32'd1);
    cs_n = 1'b1;
    @(negedge clk); ext_en = 1'b0; ext_val = 1'b1;
  endtask

  logic [31:0] got;
  int rises, oecyc, s0, o0;
  logic lvl;
  logic [RES_W:0] w;

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cs_n = 1'b1; conv_done = 1'b0; conv_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sdo_oe && !sck_oe && sck, "R6 reset outputs", {29'd0, sdo_oe, sck_oe, sck}, 32'd1);
    check(ext_mode == 1'b0, "R7 reset mode", {31'd0, ext_mode}, 32'd0);

    // sleep holds the word; a second strobe is ignored
    give_result(30'h2ABCDE01);
    repeat (20) @(negedge clk);
    give_result(30'h15555555);
    read_int(0, 0, got, rises, oecyc, lvl);
    check(got == exp_word(30'h2ABCDE01), "R5 R2 held word", got, exp_word(30'h2ABCDE01));
    check(rises == 32, "R1 rising edges", rises, 32);
    check(oecyc == 64 * HALF, "R1 frame length", oecyc, 64 * HALF);
    check(sck && conv_start && sdo, "R3 frame end", {29'd0, sck, conv_start, sdo}, 32'd7);
    check(ext_mode == 1'b0, "R7 internal mode", {31'd0, ext_mode}, 32'd0);
    repeat (5) @(negedge clk);
    check(sdo && sdo_oe, "R6 busy line high", {30'd0, sdo, sdo_oe}, 32'd3);
    cs_n = 1'b1; @(negedge clk);
    check(!sdo_oe, "R6 released", {31'd0, sdo_oe}, 32'd0);

    // chip select pulse shorter than the test interval
    give_result(30'h0F0F1234);
    s0 = starts; o0 = oe_total;
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
    check(oe_total == o0 && starts == s0, "R8 no frame", oe_total + starts, o0 + s0);
    read_int(0, 0, got, rises, oecyc, lvl);
    check(got == exp_word(30'h0F0F1234), "R8 word kept", got, exp_word(30'h0F0F1234));
    cs_n = 1'b1;

    // end of frame and abort in the same cycle
    give_result(30'h3000000F);
    s0 = starts;
    read_int(32, HALF - 1, got, rises, oecyc, lvl);
    repeat (6) @(negedge clk);
    check(starts == s0 + 1, "R10 single start", starts, s0 + 1);
    check(!sck_oe, "R10 released", {31'd0, sck_oe}, 32'd0);

    // random frames: full, aborted, external
    for (int it = 0; it < 12; it++) begin
      w = RES_W'($urandom());
      w[RES_W] = $urandom_range(0, 1);
      give_result(w);
      if ($urandom_range(0, 2) == 0) begin
        read_ext(w);
      end else begin
        int ab, d;
        ab = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 31);
        d  = $urandom_range(0, 2 * HALF - 1);
        s0 = starts;
        read_int(ab, d, got, rises, oecyc, lvl);
        if (ab == 0) begin
          check(got == exp_word(w), "R2 random word", got, exp_word(w));
          check(rises == 32, "R1 random edges", rises, 32);
          cs_n = 1'b1;
        end else begin
          @(negedge clk);
          check(!sck_oe && conv_start && !sdo_oe, "R4 abort", {29'd0, sck_oe, conv_start, sdo_oe}, 32'd2);
          check(got == 32'(exp_word(w) >> (32 - rises)), "R4 prefix", got, 32'(exp_word(w) >> (32 - rises)));
          if (!lvl) begin
            // line left low: next select edge picks external mode
            @(negedge clk); cs_n = 1'b0;
            repeat (2) @(negedge clk);
            check(ext_mode == 1'b1, "R4 R7 low line", {31'd0, ext_mode}, 32'd1);
            cs_n = 1'b1;
            @(negedge clk); ext_en = 1'b1; ext_val = 1'b1;
            repeat (2) @(negedge clk); ext_en = 1'b0;
          end
        end
      end
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule